// File: doc/BRIEF.md
# Post-Increment Load Execution Unit

This unit carries out a family of integer loads in which the base register addresses memory unchanged. The base register is then advanced by an offset. A decoded operation arrives with an access size, an extension mode, an offset source, two register indices and the operand values. The unit sends one read request to memory, carrying the base value as the address and a byte count. It then waits for the returned data.

Once the data arrives, the unit extends it to the register width. In a single cycle it drives two independent write-back ports. The target port carries the loaded value. The base port carries the base plus the offset, where the offset is either a second register operand or a sign-extended 16-bit displacement.

Operand combinations that are not allowed are caught at acceptance. Such an operation raises a one-cycle illegal flag instead of touching memory or any register. No status state is changed by any operation.

Top module: `postinc_load_unit`

## Requirements
- R1: After reset, `op_ready` is 1, and `mem_req_valid`, `rt_we`, `ra_we` and `illegal` are all 0.
- R2: On acceptance, `mem_req_addr` is driven with the unchanged base value `op_ra_val`. `mem_req_bytes` follows the size code `op_size`: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Both stay stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R3: With `op_signed`=0 and a size code of 0, 1 or 2, `rt_data` holds the low 1, 2 or 4 bytes of `mem_rsp_data`, and every higher bit is 0. Response bits above the access width are ignored.
- R4: With `op_signed`=1 and a size code of 1 or 2, every bit of `rt_data` above the access width is a copy of the top bit of the loaded value.
- R5: With size code 3 and `op_signed`=0, `rt_data` equals all 64 bits of `mem_rsp_data`.
- R6: In the register-offset form (`op_use_imm`=0), `ra_data` equals `op_ra_val + op_rb_val` modulo 2^64.
- R7: The displacement form (`op_use_imm`=1) is legal only for a signed halfword. Its `ra_data` equals `op_ra_val` plus `op_disp` sign-extended to 64 bits, modulo 2^64.
- R8: The cycle after `mem_rsp_valid` is sampled, `rt_we` and `ra_we` are both 1 for exactly one cycle. In that cycle `rt_idx` is the accepted target index and `ra_idx` is the accepted base index. After that cycle `op_ready` returns to 1.
- R9: If the base index is 0 or equals the target index, `illegal` is 1 for exactly the cycle after acceptance. No request is issued and no write enable rises, and `op_ready` is 1 again the cycle after.
- R10: A signed byte, a signed doubleword, or the displacement form with anything other than a signed halfword behaves as R9 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered; accepted when `op_ready` is 1 |
| op_ready | output | 1 | Unit is idle and can accept an operation |
| op_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 doubleword) |
| op_signed | input | 1 | 1 selects sign fill, 0 selects zero fill |
| op_use_imm | input | 1 | 1 takes the offset from `op_disp`, 0 from `op_rb_val` |
| op_rt_sel | input | 5 | Target register index |
| op_ra_sel | input | 5 | Base register index |
| op_ra_val | input | 64 | Base register value |
| op_rb_val | input | 64 | Offset register value |
| op_disp | input | 16 | Signed displacement |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 4 | Bytes to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, loaded bytes at the low end |
| rt_we | output | 1 | Target write enable |
| rt_idx | output | 5 | Target write index |
| rt_data | output | 64 | Target write data |
| ra_we | output | 1 | Base write enable |
| ra_idx | output | 5 | Base write index |
| ra_data | output | 64 | Updated base value |
| illegal | output | 1 | Illegal-form pulse |

## Verification
Errors in the captured operation registers appear at the ports on the next edge. A wrong captured base shows up as a bad request address in the first request cycle. A wrong size or mode capture shows up as a bad byte count at once, and as a bad `rt_data` one cycle after the response. A state register stuck in the wait or write-back phase shows up as `op_ready` staying low. It can also show up as write enables held for more than one cycle, which the bench catches on the very next sample. A decode error is visible in the first cycle after acceptance, as either a spurious request or a missing `illegal` pulse.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_WB   = 3'd3,
    ST_ILL  = 3'd4
  } unit_state_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/pil_decode.sv
module pil_decode
  import pil_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16,
  localparam int NB_W  = $clog2(XLEN / 8) + 1
) (
  input  logic [1:0]       size,
  input  logic             sgn,
  input  logic             use_imm,
  input  logic [IDX_W-1:0] rt_sel,
  input  logic [IDX_W-1:0] ra_sel,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [DISP_W-1:0] disp,
  output logic             bad,
  output logic [NB_W-1:0]  nbytes,
  output logic [XLEN-1:0]  offset
);
  logic bad_regs;
  logic bad_form;

  always_comb begin
    bad_regs = (ra_sel == '0) || (ra_sel == rt_sel);
    bad_form = (sgn && ((size == SZ_BYTE) || (size == SZ_DWORD)))
             || (use_imm && !(sgn && (size == SZ_HALF)));
    bad      = bad_regs || bad_form;
    nbytes   = NB_W'(1) << size;
    if (use_imm)
      offset = {{(XLEN - DISP_W){disp[DISP_W-1]}}, disp};
    else
      offset = rb_val;
  end
endmodule

// File: rtl/pil_extend.sv
module pil_extend
  import pil_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] ext
);
  logic [XLEN-1:0] cand [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W = 8 << k;
    if (W >= XLEN) begin : g_full
      assign cand[k] = raw;
    end else begin : g_part
      assign cand[k] = {{(XLEN - W){sgn & raw[W-1]}}, raw[W-1:0]};
    end
  end

  assign ext = cand[size];
endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
  import pil_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16,
  localparam int NB_W  = $clog2(XLEN / 8) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic              op_use_imm,
  input  logic [IDX_W-1:0]  op_rt_sel,
  input  logic [IDX_W-1:0]  op_ra_sel,
  input  logic [XLEN-1:0]   op_ra_val,
  input  logic [XLEN-1:0]   op_rb_val,
  input  logic [DISP_W-1:0] op_disp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [NB_W-1:0]   mem_req_bytes,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              rt_we,
  output logic [IDX_W-1:0]  rt_idx,
  output logic [XLEN-1:0]   rt_data,
  output logic              ra_we,
  output logic [IDX_W-1:0]  ra_idx,
  output logic [XLEN-1:0]   ra_data,
  output logic              illegal
);
  unit_state_e     state_q;
  logic [1:0]      size_q;
  logic            sgn_q;
  logic [XLEN-1:0] sum_q;
  logic            dec_bad;
  logic [NB_W-1:0] dec_nbytes;
  logic [XLEN-1:0] dec_offset;
  logic [XLEN-1:0] ext_data;

  pil_decode #(.XLEN(XLEN), .IDX_W(IDX_W), .DISP_W(DISP_W)) u_dec (
    .size    (op_size),
    .sgn     (op_signed),
    .use_imm (op_use_imm),
    .rt_sel  (op_rt_sel),
    .ra_sel  (op_ra_sel),
    .rb_val  (op_rb_val),
    .disp    (op_disp),
    .bad     (dec_bad),
    .nbytes  (dec_nbytes),
    .offset  (dec_offset)
  );

  pil_extend #(.XLEN(XLEN)) u_ext (
    .size (size_q),
    .sgn  (sgn_q),
    .raw  (mem_rsp_data),
    .ext  (ext_data)
  );

  assign op_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      size_q        <= SZ_BYTE;
      sgn_q         <= 1'b0;
      sum_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_bytes <= '0;
      rt_we         <= 1'b0;
      rt_idx        <= '0;
      rt_data       <= '0;
      ra_we         <= 1'b0;
      ra_idx        <= '0;
      ra_data       <= '0;
      illegal       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (op_valid) begin
            if (dec_bad) begin
              illegal <= 1'b1;
              state_q <= ST_ILL;
            end else begin
              size_q        <= op_size;
              sgn_q         <= op_signed;
              sum_q         <= op_ra_val + dec_offset;
              rt_idx        <= op_rt_sel;
              ra_idx        <= op_ra_sel;
              mem_req_addr  <= op_ra_val;
              mem_req_bytes <= dec_nbytes;
              mem_req_valid <= 1'b1;
              state_q       <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rt_data <= ext_data;
            ra_data <= sum_q;
            rt_we   <= 1'b1;
            ra_we   <= 1'b1;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          rt_we   <= 1'b0;
          ra_we   <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_ILL: begin
          illegal <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes));

  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
    rt_we && !sgn_q && (size_q == SZ_BYTE) |-> rt_data[XLEN-1:8] == '0);

  assert_wb_pair_R8: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> ra_we && (rt_idx != ra_idx) && (ra_idx != '0));

  assert_wb_single_R8: assert property (@(posedge clk) disable iff (rst)
    rt_we |=> !rt_we && op_ready);

  assert_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !rt_we && !op_ready);

  assert_ill_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !mem_req_valid && !rt_we && !ra_we);

  assert_ill_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal && op_ready);
endmodule

// File: tb/postinc_load_unit_tb.sv
`timescale 1ns/1ps
module postinc_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic        op_use_imm = 1'b0;
  logic [4:0]  op_rt_sel = '0;
  logic [4:0]  op_ra_sel = '0;
  logic [63:0] op_ra_val = '0;
  logic [63:0] op_rb_val = '0;
  logic [15:0] op_disp = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [3:0]  mem_req_bytes;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rt_we;
  logic [4:0]  rt_idx;
  logic [63:0] rt_data;
  logic        ra_we;
  logic [4:0]  ra_idx;
  logic [63:0] ra_data;
  logic        illegal;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  postinc_load_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_signed(op_signed), .op_use_imm(op_use_imm),
    .op_rt_sel(op_rt_sel), .op_ra_sel(op_ra_sel), .op_ra_val(op_ra_val),
    .op_rb_val(op_rb_val), .op_disp(op_disp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
    .ra_we(ra_we), .ra_idx(ra_idx), .ra_data(ra_data), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [1:0] sz, input logic sg,
                                 input logic im, input logic [4:0] rt,
                                 input logic [4:0] ra);
    return (ra == 5'd0) || (ra == rt) || (sg && (sz == 2'd0 || sz == 2'd3))
           || (im && !(sg && sz == 2'd1));
  endfunction

  function automatic logic [63:0] exp_load(input logic [1:0] sz, input logic sg,
                                           input logic [63:0] md);
    case (sz)
      2'd0: return sg ? {{56{md[7]}}, md[7:0]} : {56'd0, md[7:0]};
      2'd1: return sg ? {{48{md[15]}}, md[15:0]} : {48'd0, md[15:0]};
      2'd2: return sg ? {{32{md[31]}}, md[31:0]} : {32'd0, md[31:0]};
      default: return md;
    endcase
  endfunction

  function automatic string load_req(input logic [1:0] sz, input logic sg);
    if (sz == 2'd3) return "R5";
    return sg ? "R4" : "R3";
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic sg, input logic im,
                        input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] rav, input logic [63:0] rbv,
                        input logic [15:0] d, input logic [63:0] md,
                        input int qlat, input int rlat);
    logic [63:0] off;
    bit bad;
    bad = exp_bad(sz, sg, im, rt, ra);
    off = im ? {{48{d[15]}}, d} : rbv;
    @(negedge clk);
    chk(op_ready == 1'b1, "R8 ready before op", 64'(op_ready), 64'd1);
    op_size = sz; op_signed = sg; op_use_imm = im; op_rt_sel = rt;
    op_ra_sel = ra; op_ra_val = rav; op_rb_val = rbv; op_disp = d;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (bad) begin
      chk(illegal == 1'b1, (sg && !im && (sz == 2'd0 || sz == 2'd3)) || im ?
          "R10 illegal flag" : "R9 illegal flag", 64'(illegal), 64'd1);
      chk(!mem_req_valid && !rt_we && !ra_we, "R9 no activity",
          {mem_req_valid, rt_we, ra_we}, 64'd0);
      @(negedge clk);
      chk(!illegal && op_ready, "R9 back to idle", {illegal, op_ready}, 64'd1);
      chk(!mem_req_valid && !rt_we, "R9 no late request",
          {mem_req_valid, rt_we}, 64'd0);
    end else begin
      chk(mem_req_valid && !illegal, "R2 request raised",
          {illegal, mem_req_valid}, 64'd1);
      chk(mem_req_addr == rav, "R2 address is base", mem_req_addr, rav);
      chk(mem_req_bytes == (4'd1 << sz), "R2 byte count",
          64'(mem_req_bytes), 64'(4'd1 << sz));
      for (int i = 0; i < qlat; i++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == rav, "R2 request held",
            mem_req_addr, rav);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_data = $urandom();
      for (int i = 0; i < rlat; i++) begin
        chk(!rt_we && !ra_we && !mem_req_valid, "R8 no early write",
            {rt_we, ra_we, mem_req_valid}, 64'd0);
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data = md;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data = {$urandom(), $urandom()};
      chk(rt_we && ra_we, "R8 both enables", {rt_we, ra_we}, 64'd3);
      chk(rt_idx == rt && ra_idx == ra, "R8 indices", {rt_idx, ra_idx},
          {rt, ra});
      chk(rt_data == exp_load(sz, sg, md), load_req(sz, sg), rt_data,
          exp_load(sz, sg, md));
      chk(ra_data == rav + off, im ? "R7 base update" : "R6 base update",
          ra_data, rav + off);
      @(negedge clk);
      chk(!rt_we && !ra_we && op_ready, "R8 single write cycle",
          {rt_we, ra_we, op_ready}, 64'd1);
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(op_ready && !mem_req_valid && !rt_we && !ra_we && !illegal,
        "R1 reset state", {op_ready, mem_req_valid, rt_we, ra_we, illegal},
        64'h10);
    // directed corners
    run_op(2'd0, 1'b0, 1'b0, 5'd3, 5'd4, 64'h1000, 64'h8,
           16'h0, 64'hFFFF_FFFF_FFFF_FF80, 0, 0);           // R3 byte
    run_op(2'd1, 1'b1, 1'b0, 5'd5, 5'd6, 64'h2000, 64'h2,
           16'h0, 64'h1234_5678_9ABC_8000, 2, 1);           // R4 half
    run_op(2'd2, 1'b1, 1'b0, 5'd7, 5'd8, 64'h3000, 64'h4,
           16'h0, 64'hFFFF_FFFF_7FFF_FFFF, 1, 3);           // R4 word positive
    run_op(2'd2, 1'b0, 1'b0, 5'd9, 5'd10, 64'h3000, 64'h4,
           16'h0, 64'hAAAA_AAAA_8765_4321, 0, 2);           // R3 word
    run_op(2'd3, 1'b0, 1'b0, 5'd11, 5'd12, 64'hFFFF_FFFF_FFFF_FFF8,
           64'h10, 16'h0, 64'hDEAD_BEEF_CAFE_F00D, 3, 0);   // R5, R6 wrap
    run_op(2'd1, 1'b1, 1'b1, 5'd13, 5'd14, 64'h100, 64'h0,
           16'hFFFC, 64'h7FFF, 0, 1);                       // R7 negative disp
    run_op(2'd1, 1'b1, 1'b1, 5'd15, 5'd16, 64'h2, 64'h0,
           16'hFFF0, 64'h0001, 1, 0);                       // R7 wrap below zero
    run_op(2'd2, 1'b0, 1'b0, 5'd3, 5'd0, 64'h40, 64'h8, 16'h0, 64'h1, 0, 0); // R9
    run_op(2'd2, 1'b0, 1'b0, 5'd6, 5'd6, 64'h40, 64'h8, 16'h0, 64'h1, 0, 0); // R9
    run_op(2'd0, 1'b1, 1'b0, 5'd1, 5'd2, 64'h40, 64'h8, 16'h0, 64'h1, 0, 0); // R10
    run_op(2'd3, 1'b1, 1'b0, 5'd1, 5'd2, 64'h40, 64'h8, 16'h0, 64'h1, 0, 0); // R10
    run_op(2'd2, 1'b0, 1'b1, 5'd1, 5'd2, 64'h40, 64'h8, 16'h4, 64'h1, 0, 0); // R10
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      logic sg, im;
      logic [4:0] rt, ra;
      sz = 2'($urandom_range(0, 3));
      sg = ($urandom_range(0, 3) == 0) ? 1'b1 : (sz == 2'd1 || sz == 2'd2) &&
           $urandom_range(0, 1) == 1;
      im = ($urandom_range(0, 7) == 0) || (sg && sz == 2'd1 &&
           $urandom_range(0, 1) == 1);
      ra = ($urandom_range(0, 15) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
      rt = ($urandom_range(0, 15) == 0) ? ra : 5'($urandom_range(0, 31));
      run_op(sz, sg, im, rt, ra, {$urandom(), $urandom()},
             {$urandom(), $urandom()}, 16'($urandom()),
             {$urandom(), $urandom()}, $urandom_range(0, 3),
             $urandom_range(0, 3));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule